// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block computes four 32-bit message-schedule words of the SM3 hash per call. It takes three 128-bit operands, each seen as four 32-bit lanes, and an operation code. It then applies one of two expansion steps. Expansion step A mixes the operand lanes by XOR and passes each mixed word through the P1 permutation. Expansion step B XORs rotated words into the destination operand and adds a correction term to the top lane.

In both steps the top lane depends on a value formed from lane 0 in the same call. This dependency is resolved within one cycle, so every call completes in a single pass. A caller issues one request per cycle with a valid strobe. One cycle later it receives a registered 128-bit result and a valid flag. Sequencing the full schedule and the compression rounds belongs to the surrounding logic.

Top module: `sm3_wexp_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_out` becomes zero and `res_valid` becomes 0, whatever the other inputs are.
- R2: Lane i of every 128-bit port occupies bits [32i+31:32i], with lane 0 in the least significant bits. P1(x) is defined as x XOR ror(x,17) XOR ror(x,9).
- R3: With code 0 (step A), output lanes 0, 1 and 2 equal P1(D[i] XOR N[i] XOR ror(M[i+1],17)).
- R4: With code 0, output lane 3 equals P1(D[3] XOR N[3] XOR ror(L0,17)), where L0 is the new output lane 0 of the same call. M lane 0 has no effect on the result.
- R5: With code 1 (step B), output lane i equals D[i] XOR N[i] XOR ror(M[i],25) for lanes 0, 1 and 2.
- R6: With code 1, let c = N[0] XOR ror(M[0],25). Output lane 3 equals D[3] XOR N[3] XOR ror(M[3],25) XOR ror(c,17) XOR ror(c,2) XOR ror(c,26).
- R7: A strobe with code 0 or 1 sets `res_valid` to 1 and updates `res_out` at the next rising edge. Back-to-back strobes each give their own result one cycle later.
- R8: Codes 2 and 3 are unallocated. A strobe carrying either code leaves `res_valid` at 0 on the next cycle and leaves `res_out` unchanged.
- R9: A cycle without a strobe drives `res_valid` to 0 on the next cycle and leaves `res_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_code | input | 2 | 0: step A, 1: step B, 2 and 3: unallocated |
| d_in | input | 128 | Destination operand D, four lanes |
| n_in | input | 128 | Operand N, four lanes |
| m_in | input | 128 | Operand M, four lanes |
| res_out | output | 128 | Registered expansion result |
| res_valid | output | 1 | High for one cycle per accepted request |

## Verification
Every result is due exactly one rising edge after the strobe that requested it. The bench changes inputs on the falling edge and then reads `res_out` and `res_valid` on the next falling edge, halfway past the edge that loads the register.

Both steps are linear over GF(2). A sweep of a single set bit across every position of D, N and M therefore checks every lane mapping and every rotation. Random operands, operands with all lanes equal, back-to-back strobes and the unallocated codes are added on top, each checked in that same sampling cycle. A hold check follows in the cycle after each of these.

// File: rtl/sm3w_pkg.sv
// Shared constants and helpers for the SM3 message expansion unit.
// Assumes 32-bit lanes; the rotation amounts below are defined for that width.
package sm3w_pkg;
    parameter int LANE_W = 32;
    parameter int LANES  = 4;
    parameter int OP_W   = 2;
    localparam int VEC_W = LANE_W * LANES;

    // Operation codes (the low two codes are allocated, the rest are not)
    localparam logic [OP_W-1:0] OPC_STEP_A = 2'd0;
    localparam logic [OP_W-1:0] OPC_STEP_B = 2'd1;

    // Rotation amounts
    localparam int A_MIX_ROT = 17;
    localparam int P1_ROT_X  = 17;
    localparam int P1_ROT_Y  = 9;
    localparam int B_MIX_ROT = 25;
    localparam int B_FIX_R1  = 17;
    localparam int B_FIX_R2  = 2;
    localparam int B_FIX_R3  = 26;

    // Rotate a lane right by a constant amount
    function automatic logic [LANE_W-1:0] rotr(input logic [LANE_W-1:0] x, input int amt);
        return (x >> amt) | (x << (LANE_W - amt));
    endfunction

    // P1 permutation of one lane
    function automatic logic [LANE_W-1:0] perm_p1(input logic [LANE_W-1:0] x);
        return x ^ rotr(x, P1_ROT_X) ^ rotr(x, P1_ROT_Y);
    endfunction
endpackage

// File: rtl/sm3w_step_a.sv
// Expansion step A: P1 of XOR-mixed lanes. The top lane mixes in the freshly
// computed lane 0 rather than an M lane. Purely combinational.
// Assumes LANES >= 2; lane 0 of M is not used.
module sm3w_step_a
    import sm3w_pkg::*;
(
    input  logic [VEC_W-1:0] d_vec,
    input  logic [VEC_W-1:0] n_vec,
    input  logic [VEC_W-1:0] m_vec,
    output logic [VEC_W-1:0] q_vec
);
    localparam int TOP = LANES - 1;

    logic [LANE_W-1:0] low_q [TOP];
    logic [LANE_W-1:0] top_mix;
    logic [LANE_W-1:0] unused_m0;

    assign unused_m0 = m_vec[LANE_W-1:0];

    // Lower lanes draw on the next-higher M lane
    for (genvar i = 0; i < TOP; i++) begin : g_low
        logic [LANE_W-1:0] mix;
        assign mix      = d_vec[i*LANE_W +: LANE_W] ^ n_vec[i*LANE_W +: LANE_W]
                        ^ rotr(m_vec[(i+1)*LANE_W +: LANE_W], A_MIX_ROT);
        assign low_q[i] = perm_p1(mix);
        assign q_vec[i*LANE_W +: LANE_W] = low_q[i];
    end

    // Top lane chains on new lane 0 within the same cycle
    assign top_mix = d_vec[TOP*LANE_W +: LANE_W] ^ n_vec[TOP*LANE_W +: LANE_W]
                   ^ rotr(low_q[0], A_MIX_ROT);
    assign q_vec[TOP*LANE_W +: LANE_W] = perm_p1(top_mix);
endmodule

// File: rtl/sm3w_step_b.sv
// Expansion step B: folds N and rotated M into D lane by lane, then adds to
// the top lane a three-rotation correction of the lane-0 N/M term.
// Purely combinational.
module sm3w_step_b
    import sm3w_pkg::*;
(
    input  logic [VEC_W-1:0] d_vec,
    input  logic [VEC_W-1:0] n_vec,
    input  logic [VEC_W-1:0] m_vec,
    output logic [VEC_W-1:0] q_vec
);
    localparam int TOP = LANES - 1;

    logic [LANE_W-1:0] nm   [LANES];
    logic [LANE_W-1:0] corr;

    // Per-lane N/M term
    for (genvar i = 0; i < LANES; i++) begin : g_nm
        assign nm[i] = n_vec[i*LANE_W +: LANE_W] ^ rotr(m_vec[i*LANE_W +: LANE_W], B_MIX_ROT);
    end

    // Correction taken from lane 0's term
    assign corr = rotr(nm[0], B_FIX_R1) ^ rotr(nm[0], B_FIX_R2) ^ rotr(nm[0], B_FIX_R3);

    // Fold into D; only the top lane receives the correction
    for (genvar i = 0; i < LANES; i++) begin : g_out
        if (i == TOP) begin : g_top
            assign q_vec[i*LANE_W +: LANE_W] = d_vec[i*LANE_W +: LANE_W] ^ nm[i] ^ corr;
        end else begin : g_plain
            assign q_vec[i*LANE_W +: LANE_W] = d_vec[i*LANE_W +: LANE_W] ^ nm[i];
        end
    end
endmodule

// File: rtl/sm3w_result_reg.sv
// Output stage: captures a result when load is high and otherwise holds it;
// the valid flag mirrors load with one cycle of delay. Synchronous active-low reset.
module sm3w_result_reg #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             vld
);
    // Result register: clear on reset, load on accept, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // Valid flag: one pulse per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= load;
    end
endmodule

// File: rtl/sm3_wexp_unit.sv
// SM3 message expansion unit top. Decodes the operation code, runs both
// expansion steps in parallel and registers the selected result.
// Assumes one request per cycle at most; unallocated codes are dropped.
module sm3_wexp_unit
    import sm3w_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [VEC_W-1:0] d_in,
    input  logic [VEC_W-1:0] n_in,
    input  logic [VEC_W-1:0] m_in,
    output logic [VEC_W-1:0] res_out,
    output logic             res_valid
);
    logic [VEC_W-1:0] a_q;
    logic [VEC_W-1:0] b_q;
    logic [VEC_W-1:0] sel_q;
    logic             legal;
    logic             accept;

    sm3w_step_a u_step_a (.d_vec(d_in), .n_vec(n_in), .m_vec(m_in), .q_vec(a_q));
    sm3w_step_b u_step_b (.d_vec(d_in), .n_vec(n_in), .m_vec(m_in), .q_vec(b_q));

    // Decode: only the two allocated codes are accepted
    always_comb begin
        legal  = (op_code == OPC_STEP_A) || (op_code == OPC_STEP_B);
        accept = in_valid && legal;
        sel_q  = (op_code == OPC_STEP_A) ? a_q : b_q;
    end

    sm3w_result_reg #(.WIDTH(VEC_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .din  (sel_q),
        .dout (res_out),
        .vld  (res_valid)
    );
endmodule

// File: rtl/sm3w_checker.sv
// Protocol checker for sm3_wexp_unit: reset, valid timing, code decode and hold.
module sm3w_checker
    import sm3w_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_code,
    input logic [VEC_W-1:0] res_out,
    input logic             res_valid
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_out == '0));

    assert_valid_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code < 2'd2) |=> res_valid);

    assert_unalloc_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code >= 2'd2) |=> !res_valid);

    assert_idle_novalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_out));
endmodule

bind sm3_wexp_unit sm3w_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_code  (op_code),
    .res_out  (res_out),
    .res_valid(res_valid)
);

// File: tb/sim_sm3_wexp_unit.sv
`timescale 1ns/1ps
module sim_sm3_wexp_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   op_code;
    logic [127:0] d_in, n_in, m_in;
    logic [127:0] res_out;
    logic         res_valid;

    int n_checks = 0;
    int n_fails  = 0;
    logic [127:0] last_res;

    always #10 clk = ~clk;

    sm3_wexp_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .d_in(d_in), .n_in(n_in), .m_in(m_in),
        .res_out(res_out), .res_valid(res_valid)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int r);
        return (x >> r) | (x << (32 - r));
    endfunction

    function automatic logic [31:0] lane(input logic [127:0] v, input int i);
        return v[i*32 +: 32];
    endfunction

    function automatic logic [31:0] p1f(input logic [31:0] x);
        return x ^ rr(x, 17) ^ rr(x, 9);
    endfunction

    function automatic logic [127:0] model_a(input logic [127:0] d, n, m);
        logic [127:0] r;
        for (int i = 0; i < 3; i++)
            r[i*32 +: 32] = p1f(lane(d, i) ^ lane(n, i) ^ rr(lane(m, i+1), 17));
        r[96 +: 32] = p1f(lane(d, 3) ^ lane(n, 3) ^ rr(r[31:0], 17));
        return r;
    endfunction

    function automatic logic [127:0] model_b(input logic [127:0] d, n, m);
        logic [127:0] r;
        logic [31:0]  c;
        c = lane(n, 0) ^ rr(lane(m, 0), 25);
        for (int i = 0; i < 4; i++)
            r[i*32 +: 32] = lane(d, i) ^ lane(n, i) ^ rr(lane(m, i), 25);
        r[96 +: 32] = r[96 +: 32] ^ rr(c, 17) ^ rr(c, 2) ^ rr(c, 26);
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request, checked one cycle later (R7), then one idle cycle checked for hold (R9)
    task automatic run_op(input logic [1:0] op, input logic [127:0] d, n, m, input string req);
        logic [127:0] exp;
        @(negedge clk);
        op_code = op; d_in = d; n_in = n; m_in = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp = (op == 2'd0) ? model_a(d, n, m) : model_b(d, n, m);
        check("R7 valid", {127'd0, res_valid}, 128'd1);
        check(req, res_out, exp);
        last_res = exp;
        @(negedge clk);
        check("R9 valid", {127'd0, res_valid}, 128'd0);
        check("R9 hold", res_out, last_res);
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        // R1: reset wins over a live strobe
        rst_n = 1'b0; in_valid = 1'b1; op_code = 2'd0;
        d_in = {4{32'hA5A5_0F0F}}; n_in = {4{32'h1234_5678}}; m_in = {4{32'hDEAD_BEEF}};
        repeat (3) @(negedge clk);
        check("R1 valid", {127'd0, res_valid}, 128'd0);
        check("R1 data", res_out, 128'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        last_res = '0;

        // R2-R6: single set bit swept across every operand bit, both steps
        for (int op = 0; op < 2; op++)
            for (int which = 0; which < 3; which++)
                for (int b = 0; b < 128; b++) begin
                    logic [127:0] one;
                    one = 128'd1 << b;
                    run_op(op[1:0], which == 0 ? one : 128'd0, which == 1 ? one : 128'd0,
                           which == 2 ? one : 128'd0,
                           op == 0 ? "R2 R3 R4 sweep" : "R2 R5 R6 sweep");
                end

        // R4: M lane 0 has no effect on step A
        run_op(2'd0, {4{32'h0F1E_2D3C}}, {4{32'h7788_99AA}}, {96'd0, 32'hFFFF_FFFF}, "R4 m0 ignored");
        check("R4 m0 ignored vs zero", res_out, model_a({4{32'h0F1E_2D3C}}, {4{32'h7788_99AA}}, 128'd0));

        // All lanes equal: exposes lane ordering errors
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = 32'h1357_9BDF * (k + 1) ^ (32'h8000_0001 << k);
            run_op(2'd0, {4{v}}, {4{~v}}, {4{v ^ 32'h5A5A_5A5A}}, "R3 R4 equal lanes");
            run_op(2'd1, {4{v}}, {4{~v}}, {4{v ^ 32'h5A5A_5A5A}}, "R5 R6 equal lanes");
        end

        // Random operands
        for (int k = 0; k < 300; k++) begin
            logic [127:0] d, n, m;
            d = {$urandom, $urandom, $urandom, $urandom};
            n = {$urandom, $urandom, $urandom, $urandom};
            m = {$urandom, $urandom, $urandom, $urandom};
            run_op(k[0] ? 2'd1 : 2'd0, d, n, m, k[0] ? "R5 R6 random" : "R3 R4 random");
        end

        // R7: back-to-back strobes, each result one cycle later
        begin
            logic [127:0] d1, d2, n1, m1;
            d1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
            d2 = ~d1; n1 = {d1[63:0], d1[127:64]}; m1 = d1 ^ 128'h5555;
            @(negedge clk);
            op_code = 2'd0; d_in = d1; n_in = n1; m_in = m1; in_valid = 1'b1;
            @(negedge clk);
            check("R7 b2b first", res_out, model_a(d1, n1, m1));
            op_code = 2'd1; d_in = d2;
            @(negedge clk);
            in_valid = 1'b0;
            check("R7 b2b valid", {127'd0, res_valid}, 128'd1);
            check("R7 b2b second", res_out, model_b(d2, n1, m1));
            last_res = model_b(d2, n1, m1);
        end

        // R8: unallocated codes drop the request and hold the result
        for (int op = 2; op < 4; op++) begin
            @(negedge clk);
            op_code = op[1:0]; d_in = ~last_res; n_in = 128'hF0; m_in = 128'h3; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R8 valid", {127'd0, res_valid}, 128'd0);
            check("R8 hold", res_out, last_res);
        end

        // R9: idle with changing operands
        @(negedge clk);
        op_code = 2'd0; d_in = 128'hFFFF; n_in = 128'h1;
        @(negedge clk);
        check("R9 idle valid", {127'd0, res_valid}, 128'd0);
        check("R9 idle hold", res_out, last_res);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule